// File: doc/BRIEF.md
# Receive Frame Interrupt Coalescing Queue

This block gathers interrupt events from every receive channel and records each one as a 32-bit entry in a circular table in system memory. Frame-received events also feed one shared down-counter. The single global interrupt line rises only when enough frame entries have been written since the last reload. Events of any other kind raise the line as soon as their entry has been written, and they leave the counter alone. The host keeps the line high until it acknowledges it.

Upstream logic merges the channel events into one stream with a frame flag, an event code and a channel number. Before the host enables interrupts, it pulses an initialise input that sets the write pointer to the table base and loads the counter with the threshold. The threshold may be rewritten at any time. A new value is used from the next reload onward.

A table entry belongs to the host while its valid bit is set. The entry that carries the wrap bit closes the ring. Before each write, the block reads the entry under its pointer. If the host still owns that entry, the block holds the write back, raises a sticky overflow flag and retries after a fixed pause.

The controller has five states:
- `ST_IDLE`: waits for a queued event. A non-empty queue moves it to `ST_READ`.
- `ST_READ`: reads the entry at the pointer. The memory acknowledge moves it to `ST_EVAL`.
- `ST_EVAL`: checks the valid bit it read. A set bit moves it to `ST_HOLD`; a clear bit moves it to `ST_WRITE`.
- `ST_HOLD`: counts down the retry pause. Expiry moves it back to `ST_READ`.
- `ST_WRITE`: writes the entry. The memory acknowledge pops the event, advances the pointer and returns to `ST_IDLE`.

Initialise forces `ST_IDLE` from any state.

Top module: `frm_irq_queue`

## Requirements
- R1: A `cfg_init` pulse sets the pointer to `cfg_base` with its low two bits cleared and loads the counter from `cfg_thresh`. It also clears `gint` and `ovf` and empties the event queue.
- R2: Each accepted event produces one memory write at the pointer. `mem_req` and `mem_addr` hold until `mem_ack`. The entry holds: bit 31 valid = 1, bit 30 = the wrap bit read from that slot, bit 29 = 1 for a frame event and 0 otherwise, bits 27:24 = the event code, the low `CH_W` bits = the channel, and all other bits 0.
- R3: After each write, the pointer advances by 4 bytes. It returns to the base instead if the written slot carried the wrap bit. Every address is word aligned.
- R4: If the slot read before a write has bit 31 set, no write is made and `ovf` is set. The read is retried `RETRY_CYC` cycles later, and the write proceeds once the host has cleared the bit.
- R5: Each written frame entry decrements the shared counter. The write that brings the count to its end raises `gint` on the cycle after that write's acknowledge, and the counter reloads from `cfg_thresh`.
- R6: A written non-frame entry raises `gint` at once and leaves the counter unchanged.
- R7: `gint` stays high until `irq_ack` is sampled high.
- R8: A change of `cfg_thresh` does not alter the count in progress. It applies from the next reload.
- R9: Events offered while `irq_en` is low are neither written nor counted.
- R10: An event offered while the queue is full is dropped and sets `ovf`. `ovf` stays set until `cfg_init`.
- R11: A threshold of 0 acts as 1, so every frame entry raises `gint`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_init | input | 1 | Initialise pointer, counter and flags |
| cfg_base | input | ADDR_W | Table base byte address |
| cfg_thresh | input | CNT_W | Frame count per global interrupt |
| irq_en | input | 1 | Accept events when high |
| evt_valid | input | 1 | Event strobe |
| evt_rxf | input | 1 | 1 = frame received, 0 = other exception |
| evt_code | input | 4 | Event code |
| evt_chan | input | CH_W | Channel number |
| irq_ack | input | 1 | Host acknowledge of the global interrupt |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the entry |
| mem_wdata | output | 32 | Entry to write |
| mem_rdata | input | 32 | Entry read back |
| mem_ack | input | 1 | Memory completes the access |
| gint | output | 1 | Global interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Timing is counted from the clock edge that samples an event, with a memory that acknowledges one cycle after each request:
- The read is acknowledged on the second edge after that.
- The write is acknowledged on the fifth edge.
- `gint` and the pointer change on the sixth edge.

Each event task therefore waits ten cycles and samples at the falling edge. A blocked slot costs an extra `RETRY_CYC` plus about four cycles per attempt, so the retry test waits twenty cycles after the host frees the slot. The queue-full test samples `ovf` right after an eight-event burst. That is before any wrap-around read could happen, so only a dropped event can have set the flag.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
    localparam int CODE_W  = 4;
    localparam int ENTRY_W = 32;
    localparam int V_BIT   = 31;
    localparam int W_BIT   = 30;
    localparam int RXF_BIT = 29;
    localparam int CODE_LO = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_HOLD,
        ST_WRITE
    } q_state_e;
endpackage

// File: rtl/frm_evq.sv
module frm_evq #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slot[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) slot[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/frm_thr_cnt.sv
module frm_thr_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [CNT_W-1:0] thresh,
    input  logic             dec,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_thr;

    // a zero threshold behaves as one frame per interrupt
    assign eff_thr = (thresh == '0) ? CNT_W'(1) : thresh;
    assign hit     = dec && (cnt_q <= CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (init) begin
            cnt_q <= eff_thr;
        end else if (dec) begin
            cnt_q <= hit ? eff_thr : cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/frm_irq_queue.sv
module frm_irq_queue
    import frm_irq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CH_W      = 6,
    parameter int CNT_W     = 8,
    parameter int QDEPTH    = 4,
    parameter int RETRY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_init,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic              irq_en,
    input  logic              evt_valid,
    input  logic              evt_rxf,
    input  logic [3:0]        evt_code,
    input  logic [CH_W-1:0]   evt_chan,
    input  logic              irq_ack,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              gint,
    output logic              ovf
);
    localparam int EV_W  = 1 + CODE_W + CH_W;
    localparam int PAD_W = CODE_LO - CH_W;
    localparam int HC_W  = $clog2(RETRY_CYC + 1);

    q_state_e          state_q, state_d;
    logic [ADDR_W-1:0] base_q, ptr_q;
    logic              rd_v_q, rd_w_q;
    logic [HC_W-1:0]   hold_q;
    logic              gint_q, ovf_q;

    logic [EV_W-1:0]   q_din, q_dout;
    logic              q_empty, q_full, q_push, q_pop;
    logic              cur_rxf;
    logic [3:0]        cur_code;
    logic [CH_W-1:0]   cur_chan;
    logic              wr_done, cnt_hit, evt_take, evt_drop;

    assign evt_take = evt_valid && irq_en && !cfg_init;
    assign evt_drop = evt_take && q_full;
    assign q_push   = evt_take;
    assign q_din    = {evt_rxf, evt_code, evt_chan};
    assign {cur_rxf, cur_code, cur_chan} = q_dout;
    assign wr_done  = (state_q == ST_WRITE) && mem_ack;
    assign q_pop    = wr_done;

    frm_evq #(.W(EV_W), .DEPTH(QDEPTH)) evq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cfg_init),
        .push  (q_push),
        .din   (q_din),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    frm_thr_cnt #(.CNT_W(CNT_W)) thr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init   (cfg_init),
        .thresh (cfg_thresh),
        .dec    (wr_done && cur_rxf),
        .hit    (cnt_hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!q_empty)        state_d = ST_READ;
            ST_READ:  if (mem_ack)         state_d = ST_EVAL;
            ST_EVAL:  state_d = rd_v_q ? ST_HOLD : ST_WRITE;
            ST_HOLD:  if (hold_q == '0)    state_d = ST_READ;
            ST_WRITE: if (mem_ack)         state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
        if (cfg_init) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_wr    = (state_q == ST_WRITE);
        mem_addr  = ptr_q;
        mem_wdata = {1'b1, rd_w_q, cur_rxf, 1'b0, cur_code,
                     {PAD_W{1'b0}}, cur_chan};
        gint      = gint_q;
        ovf       = ovf_q;
    end

    // pointer, captured slot bits, retry timer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr_q  <= '0;
            rd_v_q <= 1'b0;
            rd_w_q <= 1'b0;
            hold_q <= '0;
            gint_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (cfg_init) begin
            base_q <= {cfg_base[ADDR_W-1:2], 2'b00};
            ptr_q  <= {cfg_base[ADDR_W-1:2], 2'b00};
            rd_v_q <= 1'b0;
            rd_w_q <= 1'b0;
            hold_q <= '0;
            gint_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (state_q == ST_READ && mem_ack) begin
                rd_v_q <= mem_rdata[V_BIT];
                rd_w_q <= mem_rdata[W_BIT];
            end
            if (state_q == ST_EVAL && rd_v_q) begin
                ovf_q  <= 1'b1;
                hold_q <= HC_W'(RETRY_CYC - 1);
            end
            if (state_q == ST_HOLD && hold_q != '0) hold_q <= hold_q - HC_W'(1);
            if (evt_drop) ovf_q <= 1'b1;
            if (wr_done) ptr_q <= rd_w_q ? base_q : ptr_q + ADDR_W'(4);
            if (wr_done && (cnt_hit || !cur_rxf)) gint_q <= 1'b1;
            else if (irq_ack)                     gint_q <= 1'b0;
        end
    end
endmodule

// File: rtl/frm_irq_queue_chk.sv
module frm_irq_queue_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_init,
    input logic              irq_ack,
    input logic              mem_req,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              gint,
    input logic              ovf
);
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_init |=> (!gint && !ovf)); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !cfg_init) |=> (mem_req && $stable(mem_addr))); // R2
    AST_WR_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_wr) |-> mem_wdata[31]); // R2
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_GINT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gint) |-> $past(mem_req && mem_wr && mem_ack)); // R5
    AST_GINT_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (gint && !irq_ack && !cfg_init) |=> gint); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !cfg_init) |=> ovf); // R10
endmodule

bind frm_irq_queue frm_irq_queue_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/frm_irq_queue_tb_top.sv
module frm_irq_queue_tb_top;
    localparam int ADDR_W = 16;
    localparam int CH_W   = 6;
    localparam int CNT_W  = 8;
    localparam logic [31:0] WRAP = 32'h4000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_init = 1'b0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [CNT_W-1:0]  cfg_thresh = '0;
    logic              irq_en = 1'b0;
    logic              evt_valid = 1'b0;
    logic              evt_rxf = 1'b0;
    logic [3:0]        evt_code = '0;
    logic [CH_W-1:0]   evt_chan = '0;
    logic              irq_ack = 1'b0;
    logic              mem_req, mem_wr, gint, ovf;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              mem_ack = 1'b0;

    logic [31:0] mem [16];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    frm_irq_queue #(.ADDR_W(ADDR_W), .CH_W(CH_W), .CNT_W(CNT_W)) dut_i (.*);

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[5:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    function automatic logic [31:0] ent(bit w, bit rxf, logic [3:0] code, logic [CH_W-1:0] ch);
        return {1'b1, w, rxf, 1'b0, code, 18'b0, ch};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic init(logic [ADDR_W-1:0] base, logic [CNT_W-1:0] thr);
        @(negedge clk);
        cfg_base = base; cfg_thresh = thr; cfg_init = 1'b1;
        @(negedge clk);
        cfg_init = 1'b0;
    endtask

    task automatic send(bit rxf, logic [3:0] code, logic [CH_W-1:0] ch);
        @(negedge clk);
        evt_valid = 1'b1; evt_rxf = rxf; evt_code = code; evt_chan = ch;
        @(negedge clk);
        evt_valid = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic clear_table();
        mem[4] = '0; mem[5] = '0; mem[6] = WRAP;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("reset gint", 32'(gint), 0);
        check("reset ovf", 32'(ovf), 0);
        check("reset mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic();
        clear_table();
        init(16'h0010, 8'd3);
        irq_en = 1'b1;
        send(1'b1, 4'h0, 6'd5);
        send(1'b1, 4'h0, 6'd6);
        check("R2 first entry at base", mem[4], ent(0, 1, 0, 5));
        check("R3 second entry +4", mem[5], ent(0, 1, 0, 6));
        check("R5 no gint below threshold", 32'(gint), 0);
        send(1'b1, 4'h0, 6'd7);
        check("R3 wrap bit kept", mem[6], ent(1, 1, 0, 7));
        check("R5 gint at threshold", 32'(gint), 1);
    endtask

    task automatic t_hold();
        repeat (5) @(negedge clk);
        check("R7 gint held", 32'(gint), 1);
        ack_irq();
        check("R7 gint cleared by ack", 32'(gint), 0);
    endtask

    task automatic t_block();
        send(1'b0, 4'h3, 6'd2);
        check("R4 overflow on busy slot", 32'(ovf), 1);
        check("R4 busy slot untouched", mem[4], ent(0, 1, 0, 5));
        mem[4] = '0;
        repeat (20) @(negedge clk);
        check("R4 write after release", mem[4], ent(0, 0, 3, 2));
        check("R6 exception raises gint", 32'(gint), 1);
        ack_irq();
    endtask

    task automatic t_thresh();
        cfg_thresh = 8'd1;
        mem[5] = '0; mem[6] = WRAP;
        send(1'b1, 4'h0, 6'd8);
        check("R8 old count kept", 32'(gint), 0);
        send(1'b1, 4'h0, 6'd9);
        check("R6 exception did not count", 32'(gint), 0);
        mem[4] = '0;
        send(1'b1, 4'h0, 6'd10);
        check("R5 gint at end of count", mem[4], ent(0, 1, 0, 10));
        check("R5 gint raised", 32'(gint), 1);
        ack_irq();
        mem[5] = '0;
        send(1'b1, 4'h0, 6'd11);
        check("R8 new threshold after reload", 32'(gint), 1);
        ack_irq();
    endtask

    task automatic t_disabled();
        irq_en = 1'b0;
        mem[6] = WRAP;
        send(1'b1, 4'h0, 6'd12);
        check("R9 no write when disabled", mem[6], WRAP);
        check("R9 no gint when disabled", 32'(gint), 0);
        irq_en = 1'b1;
    endtask

    task automatic t_zero();
        init(16'h0012, 8'd0);
        check("R1 init clears ovf", 32'(ovf), 0);
        clear_table();
        send(1'b1, 4'h0, 6'd13);
        check("R1 pointer back at aligned base", mem[4], ent(0, 1, 0, 13));
        check("R11 zero threshold acts as one", 32'(gint), 1);
        ack_irq();
    endtask

    task automatic t_full();
        init(16'h0010, 8'd15);
        clear_table();
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            evt_valid = 1'b1; evt_rxf = 1'b1; evt_code = 4'h0; evt_chan = CH_W'(20 + i);
            @(negedge clk);
        end
        evt_valid = 1'b0;
        check("R10 drop on full queue", 32'(ovf), 1);
        repeat (60) @(negedge clk);
        check("R10 first burst entry written", mem[4], ent(0, 1, 0, 20));
        check("R10 ovf sticky", 32'(ovf), 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        t_reset();
        t_basic();
        t_hold();
        t_block();
        t_thresh();
        t_disabled();
        t_zero();
        t_full();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end
endmodule